// File: doc/BRIEF.md
# DSP Coprocessor Register Bank with Complex Accumulator

This block holds the fifteen programmable registers of a DSP coprocessor and presents them to the host core over a 32-bit memory-mapped bus. The core reaches them with 16-bit (word) or 32-bit (double-word) accesses. Each register has a fixed access rule. Most registers can be read and written. Four status registers reflect external inputs and can only be read. One command register can only be written, and its value drives an output port.

The centrepiece is a complex accumulator made of two 34-bit halves, one real and one imaginary. The core never sees the whole accumulator. It moves a 16-bit window, bits 30 down to 15, of each half. When the core loads that window, the block builds the rest of the half: guard bits above the window copy its top bit, the low bits are cleared, and the rounding bit from the parameter register is placed just below the window. A separate command-list port loads the accumulator directly. It has a basic form that takes a window like the core does, and an extended form that takes every bit below the guard bits.

Bus reads return data one cycle after the access. An access that is not aligned to its size is refused and flagged.

Top module: `dspreg_bank`

## Requirements
- R1: After a synchronous reset, these all read as zero: every writable register, both accumulator halves, `halt_word`, `bus_rdata` and `bus_err`.
- R2: The read-write registers sit at these offsets: 0x000 (parameter, with rounding bit at bit 0), 0x008, 0x00C, 0x010, 0x018, 0x020, 0x024, 0x100C and 0x1010. A double-word read returns the whole register on `bus_rdata` in the cycle after the access. A word access with offset bit 1 set reaches bits 31:16, and with it clear reaches bits 15:0. A word write takes its data from `bus_wdata[15:0]`. A word read returns the half in `bus_rdata[15:0]` with the upper bits zero.
- R3: The read-only registers are at 0x004, 0x1000, 0x1008 and 0x1014. Reads of these return `ovf_in`, `lstat_in`, `irq_in` and `nmi_in` respectively, as sampled in the access cycle. Writes to them have no effect.
- R4: The write-only register is at 0x1004. A write to it updates `halt_word`, and a read of it returns zero.
- R5: A double-word read at 0x014 returns the imaginary bits 30:15 in `bus_rdata[31:16]` and the real bits 30:15 in `bus_rdata[15:0]`. A word read at 0x014 returns the real window, and a word read at 0x016 returns the imaginary window.
- R6: A core double-word write at 0x014 loads `bus_wdata[15:0]` into real bits 30:15 and `bus_wdata[31:16]` into imaginary bits 30:15. In each half, bits 33:31 copy bit 30, bit 14 takes parameter bit 0, and bits 13:0 are cleared. A word write at 0x014 or 0x016 rebuilds only the real or only the imaginary half, respectively.
- R7: A basic command-list load (`cl_ld`) puts `cl_re` and `cl_im` into bits 30:15 of the two halves. Bits 33:31 copy bit 30, and bits 14:0 are cleared.
- R8: An extended command-list load (`cl_xld`) puts `cl_xre` and `cl_xim` into bits 30:0 of the two halves, with bits 33:31 copying bit 30.
- R9: When several accumulator loads fall in the same cycle, the extended load wins over the basic load, and the basic load wins over a core write.
- R10: A double-word access with offset bits 1:0 not zero, or a word access with offset bit 0 set, changes no register. Such an access raises `bus_err` for the next cycle only, and if it is a read it returns zero.
- R11: An offset that maps to no register reads as zero. A write to it has no effect and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_dword | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | 13 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Misalignment flag for the previous access |
| ovf_in | input | 32 | Overflow status source |
| lstat_in | input | 32 | Command-list status source |
| irq_in | input | 32 | DSP interrupt status source |
| nmi_in | input | 32 | Non-maskable interrupt status source |
| cl_ld | input | 1 | Basic command-list accumulator load |
| cl_re | input | 16 | Basic load real window |
| cl_im | input | 16 | Basic load imaginary window |
| cl_xld | input | 1 | Extended command-list accumulator load |
| cl_xre | input | 31 | Extended load real bits 30:0 |
| cl_xim | input | 31 | Extended load imaginary bits 30:0 |
| acc_re | output | 34 | Accumulator real half |
| acc_im | output | 34 | Accumulator imaginary half |
| halt_word | output | 32 | Value last written to the write-only register |

## Verification
The hardest states to reach are collisions on the accumulator. One is a core write landing in the same cycle as a command-list load. Another is both command-list loads at once. The stimulus reaches them by raising the bus request and the load strobes together in a single cycle, using windows whose top bits differ so that each source leaves a distinct bit pattern. A misaligned double-word write at the imaginary window offset is aimed at the accumulator too, so that a refused access would show up as a changed half.

// File: rtl/dspreg_pkg.sv
package dspreg_pkg;

    localparam int OFF_W   = 13;
    localparam int DATA_W  = 32;
    localparam int HALF_W  = DATA_W / 2;
    localparam int ACC_W   = 34;
    localparam int WIN_LO  = 15;
    localparam int WIN_W   = 16;
    localparam int EXT_W   = WIN_LO + WIN_W;
    localparam int GUARD_W = ACC_W - EXT_W;
    localparam int NUM_RW  = 9;
    localparam int NUM_RO  = 4;
    localparam int SLOT_W  = $clog2(NUM_RW);
    localparam int WIDX_W  = OFF_W - 2;

    typedef enum logic [2:0] {K_NONE, K_RW, K_RO, K_WO, K_ACC} kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [SLOT_W-1:0] slot;
    } dec_t;

    typedef logic [ACC_W-1:0] acc_t;

    function automatic dec_t mk(input kind_e k, input int s);
        dec_t d;
        d.kind = k;
        d.slot = SLOT_W'(s);
        return d;
    endfunction

    // Word-index map; the offsets are fixed because software depends on them.
    function automatic dec_t map_word(input logic [WIDX_W-1:0] w);
        case (w)
            11'h000: return mk(K_RW, 0);
            11'h001: return mk(K_RO, 0);
            11'h002: return mk(K_RW, 1);
            11'h003: return mk(K_RW, 2);
            11'h004: return mk(K_RW, 3);
            11'h005: return mk(K_ACC, 0);
            11'h006: return mk(K_RW, 4);
            11'h008: return mk(K_RW, 5);
            11'h009: return mk(K_RW, 6);
            11'h400: return mk(K_RO, 1);
            11'h401: return mk(K_WO, 0);
            11'h402: return mk(K_RO, 2);
            11'h403: return mk(K_RW, 7);
            11'h404: return mk(K_RW, 8);
            11'h405: return mk(K_RO, 3);
            default: return mk(K_NONE, 0);
        endcase
    endfunction

    function automatic acc_t fill_core(input logic [WIN_W-1:0] win, input logic rnd);
        return {{GUARD_W{win[WIN_W-1]}}, win, rnd, {(WIN_LO-1){1'b0}}};
    endfunction

    function automatic acc_t fill_basic(input logic [WIN_W-1:0] win);
        return {{GUARD_W{win[WIN_W-1]}}, win, {WIN_LO{1'b0}}};
    endfunction

    function automatic acc_t fill_ext(input logic [EXT_W-1:0] v);
        return {{GUARD_W{v[EXT_W-1]}}, v};
    endfunction

endpackage

// File: rtl/dspreg_decode.sv
module dspreg_decode
    import dspreg_pkg::*;
(
    input  logic [OFF_W-1:0] addr,
    input  logic             dword,
    output dec_t             dec,
    output logic             misal
);
    always_comb begin
        misal = dword ? (addr[1:0] != 2'b00) : addr[0];
        dec   = map_word(addr[OFF_W-1:2]);
    end
endmodule

// File: rtl/dspreg_acc.sv
module dspreg_acc
    import dspreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              core_we_re,
    input  logic              core_we_im,
    input  logic [WIN_W-1:0]  core_win_re,
    input  logic [WIN_W-1:0]  core_win_im,
    input  logic              rnd,
    input  logic              bas_ld,
    input  logic [WIN_W-1:0]  bas_re,
    input  logic [WIN_W-1:0]  bas_im,
    input  logic              ext_ld,
    input  logic [EXT_W-1:0]  ext_re,
    input  logic [EXT_W-1:0]  ext_im,
    output acc_t              acc_re,
    output acc_t              acc_im
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_re <= '0;
            acc_im <= '0;
        end else if (ext_ld) begin
            acc_re <= fill_ext(ext_re);
            acc_im <= fill_ext(ext_im);
        end else if (bas_ld) begin
            acc_re <= fill_basic(bas_re);
            acc_im <= fill_basic(bas_im);
        end else begin
            if (core_we_re) acc_re <= fill_core(core_win_re, rnd);
            if (core_we_im) acc_im <= fill_core(core_win_im, rnd);
        end
    end
endmodule

// File: rtl/dspreg_bank.sv
module dspreg_bank
    import dspreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_dword,
    input  logic [12:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic [31:0]       ovf_in,
    input  logic [31:0]       lstat_in,
    input  logic [31:0]       irq_in,
    input  logic [31:0]       nmi_in,
    input  logic              cl_ld,
    input  logic [15:0]       cl_re,
    input  logic [15:0]       cl_im,
    input  logic              cl_xld,
    input  logic [30:0]       cl_xre,
    input  logic [30:0]       cl_xim,
    output logic [33:0]       acc_re,
    output logic [33:0]       acc_im,
    output logic [31:0]       halt_word
);
    dec_t                          dec;
    logic                          misal;
    logic [DATA_W-1:0]             rw_q [NUM_RW];
    logic [DATA_W-1:0]             ro_v [NUM_RO];
    logic [NUM_RW-1:0]             hit_rw;
    logic                          wr_ok, lo_en, hi_en;
    logic [HALF_W-1:0]             hi_data;
    logic                          acc_we_re, acc_we_im;
    logic [WIN_W-1:0]              acc_win_im;
    logic                          rnd_bit;
    logic [DATA_W-1:0]             rv, rsel;

    dspreg_decode u_dec (
        .addr  (bus_addr),
        .dword (bus_dword),
        .dec   (dec),
        .misal (misal)
    );

    assign ro_v[0] = ovf_in;
    assign ro_v[1] = lstat_in;
    assign ro_v[2] = irq_in;
    assign ro_v[3] = nmi_in;

    assign wr_ok   = bus_sel && bus_we && !misal;
    assign lo_en   = wr_ok && (bus_dword || !bus_addr[1]);
    assign hi_en   = wr_ok && (bus_dword || bus_addr[1]);
    assign hi_data = bus_dword ? bus_wdata[DATA_W-1:HALF_W] : bus_wdata[HALF_W-1:0];
    assign rnd_bit = rw_q[0][0];

    generate
        for (genvar i = 0; i < NUM_RW; i++) begin : g_hit
            assign hit_rw[i] = (dec.kind == K_RW) && (dec.slot == SLOT_W'(i));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_RW; i++) rw_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_RW; i++) begin
                if (hit_rw[i] && lo_en) rw_q[i][HALF_W-1:0]      <= bus_wdata[HALF_W-1:0];
                if (hit_rw[i] && hi_en) rw_q[i][DATA_W-1:HALF_W] <= hi_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_word <= '0;
        end else if (dec.kind == K_WO) begin
            if (lo_en) halt_word[HALF_W-1:0]      <= bus_wdata[HALF_W-1:0];
            if (hi_en) halt_word[DATA_W-1:HALF_W] <= hi_data;
        end
    end

    assign acc_we_re  = (dec.kind == K_ACC) && lo_en;
    assign acc_we_im  = (dec.kind == K_ACC) && hi_en;
    assign acc_win_im = hi_data;

    dspreg_acc u_acc (
        .clk         (clk),
        .rst         (rst),
        .core_we_re  (acc_we_re),
        .core_we_im  (acc_we_im),
        .core_win_re (bus_wdata[WIN_W-1:0]),
        .core_win_im (acc_win_im),
        .rnd         (rnd_bit),
        .bas_ld      (cl_ld),
        .bas_re      (cl_re),
        .bas_im      (cl_im),
        .ext_ld      (cl_xld),
        .ext_re      (cl_xre),
        .ext_im      (cl_xim),
        .acc_re      (acc_re),
        .acc_im      (acc_im)
    );

    always_comb begin
        case (dec.kind)
            K_RW:    rv = rw_q[dec.slot];
            K_RO:    rv = ro_v[dec.slot[1:0]];
            K_ACC:   rv = {acc_im[EXT_W-1:WIN_LO], acc_re[EXT_W-1:WIN_LO]};
            default: rv = '0;
        endcase
        if (bus_dword)        rsel = rv;
        else if (bus_addr[1]) rsel = {{HALF_W{1'b0}}, rv[DATA_W-1:HALF_W]};
        else                  rsel = {{HALF_W{1'b0}}, rv[HALF_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= bus_sel && misal;
            if (bus_sel && !bus_we) bus_rdata <= misal ? '0 : rsel;
        end
    end
endmodule

// File: rtl/dspreg_bank_chk.sv
module dspreg_bank_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [12:0] bus_addr,
    input logic [31:0] bus_rdata,
    input logic        bus_err,
    input logic        misal,
    input logic        acc_we_re,
    input logic        rnd_bit,
    input logic        cl_ld,
    input logic [15:0] cl_re,
    input logic        cl_xld,
    input logic [30:0] cl_xre,
    input logic [30:0] cl_xim,
    input logic [33:0] acc_re,
    input logic [33:0] acc_im
);
    a_r10_flag_set: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && misal) |=> bus_err);

    a_r10_flag_clear: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && misal) |=> !bus_err);

    a_r10_acc_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && misal && !cl_ld && !cl_xld) |=> ($stable(acc_re) && $stable(acc_im)));

    a_r4_wo_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == 13'h1004) |=> (bus_rdata == 32'h0));

    a_r6_round_insert: assert property (@(posedge clk) disable iff (rst)
        (acc_we_re && !cl_ld && !cl_xld) |=> (acc_re[14] == $past(rnd_bit) && acc_re[13:0] == 14'h0));

    a_r7_basic_load: assert property (@(posedge clk) disable iff (rst)
        (cl_ld && !cl_xld) |=> (acc_re[30:15] == $past(cl_re) && acc_re[14:0] == 15'h0));

    a_r8_ext_load: assert property (@(posedge clk) disable iff (rst)
        cl_xld |=> (acc_re[30:0] == $past(cl_xre) && acc_im[30:0] == $past(cl_xim)));

    a_r6_guard_copy: assert property (@(posedge clk) disable iff (rst)
        (acc_re[33:31] == {3{acc_re[30]}}) && (acc_im[33:31] == {3{acc_im[30]}}));
endmodule

bind dspreg_bank dspreg_bank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .misal     (misal),
    .acc_we_re (acc_we_re),
    .rnd_bit   (rnd_bit),
    .cl_ld     (cl_ld),
    .cl_re     (cl_re),
    .cl_xld    (cl_xld),
    .cl_xre    (cl_xre),
    .cl_xim    (cl_xim),
    .acc_re    (acc_re),
    .acc_im    (acc_im)
);

// File: tb/dspreg_bank_test.sv
`timescale 1ns/1ps
module dspreg_bank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0, bus_dword = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [31:0] ovf_in = '0, lstat_in = '0, irq_in = '0, nmi_in = '0;
    logic        cl_ld = 1'b0, cl_xld = 1'b0;
    logic [15:0] cl_re = '0, cl_im = '0;
    logic [30:0] cl_xre = '0, cl_xim = '0;
    logic [33:0] acc_re, acc_im;
    logic [31:0] halt_word;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        pend = 1'b0;

    always #10 clk = ~clk;

    dspreg_bank uut (.*);

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [33:0] f_core(input logic [15:0] w, input logic r);
        return {{3{w[15]}}, w, r, 14'h0};
    endfunction
    function automatic logic [33:0] f_bas(input logic [15:0] w);
        return {{3{w[15]}}, w, 15'h0};
    endfunction
    function automatic logic [33:0] f_ext(input logic [30:0] v);
        return {{3{v[30]}}, v};
    endfunction

    // Monitor: a read driven before a negedge is answered at the next negedge.
    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                chk(64'h1, 64'h0, "queue underflow");
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({32'h0, bus_rdata}, {32'h0, e}, t);
            end
        end
        pend = bus_sel && !bus_we && !rst;
    end

    task automatic bus(input logic we, input logic dw, input logic [12:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_sel = 1'b1; bus_we = we; bus_dword = dw; bus_addr = a; bus_wdata = d;
        cl_ld = 1'b0; cl_xld = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); #2;
        bus_sel = 1'b0; bus_we = 1'b0; cl_ld = 1'b0; cl_xld = 1'b0;
    endtask

    task automatic rd(input logic dw, input logic [12:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus(1'b0, dw, a, 32'h0);
    endtask

    task automatic wr(input logic dw, input logic [12:0] a, input logic [31:0] d);
        bus(1'b1, dw, a, d);
    endtask

    initial begin
        #4_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1 reset state
        chk({30'h0, acc_re}, 64'h0, "R1 acc_re");
        chk({30'h0, acc_im}, 64'h0, "R1 acc_im");
        chk({32'h0, halt_word}, 64'h0, "R1 halt_word");
        chk({32'h0, bus_rdata}, 64'h0, "R1 rdata");
        chk({63'h0, bus_err}, 64'h0, "R1 err");
        rd(1, 13'h000, 32'h0, "R1 param after reset");
        rd(1, 13'h1010, 32'h0, "R1 ext reg after reset");

        // R2 read-write registers and half accesses
        wr(1, 13'h000, 32'hA5A5_0001);
        wr(1, 13'h008, 32'h1234_5678);
        wr(1, 13'h100C, 32'hCAFE_F00D);
        wr(1, 13'h024, 32'h0BAD_1DEA);
        wr(0, 13'h00A, 32'h0000_BEEF);
        rd(1, 13'h000, 32'hA5A5_0001, "R2 param");
        rd(1, 13'h008, 32'hBEEF_5678, "R2 word write upper half");
        rd(1, 13'h100C, 32'hCAFE_F00D, "R2 mask reg");
        rd(1, 13'h024, 32'h0BAD_1DEA, "R2 last dedicated reg");
        rd(0, 13'h00A, 32'h0000_BEEF, "R2 word read upper");
        rd(0, 13'h008, 32'h0000_5678, "R2 word read lower");

        // R3 read-only registers
        ovf_in = 32'h0000_0F0F; lstat_in = 32'h1357_9BDF;
        irq_in = 32'h8000_0001; nmi_in = 32'h0000_0042;
        wr(1, 13'h004, 32'hFFFF_FFFF);
        wr(1, 13'h1008, 32'h0000_0000);
        rd(1, 13'h004, 32'h0000_0F0F, "R3 ovf read, write ignored");
        rd(1, 13'h1000, 32'h1357_9BDF, "R3 list status");
        rd(1, 13'h1008, 32'h8000_0001, "R3 irq read, write ignored");
        rd(0, 13'h1016, 32'h0000_0000, "R3 nmi upper word");
        rd(0, 13'h1014, 32'h0000_0042, "R3 nmi lower word");

        // R4 write-only register
        wr(1, 13'h1004, 32'h0000_00A5);
        idle();
        chk({32'h0, halt_word}, 64'hA5, "R4 halt_word updated");
        rd(1, 13'h1004, 32'h0, "R4 write-only reads zero");

        // R6 / R5 core accumulator access (rounding bit = 1)
        wr(1, 13'h014, 32'h8001_7FFF);
        idle();
        chk({30'h0, acc_re}, {30'h0, f_core(16'h7FFF, 1'b1)}, "R6 real half");
        chk({30'h0, acc_im}, {30'h0, f_core(16'h8001, 1'b1)}, "R6 imag half sign fill");
        rd(1, 13'h014, 32'h8001_7FFF, "R5 dword window read");
        rd(0, 13'h016, 32'h0000_8001, "R5 word imag window");
        rd(0, 13'h014, 32'h0000_7FFF, "R5 word real window");
        wr(1, 13'h000, 32'h0000_0000);
        wr(0, 13'h016, 32'h0000_1234);
        idle();
        chk({30'h0, acc_im}, {30'h0, f_core(16'h1234, 1'b0)}, "R6 word write imag, rnd 0");
        chk({30'h0, acc_re}, {30'h0, f_core(16'h7FFF, 1'b1)}, "R6 real untouched by word write");

        // R7 basic command-list load
        @(posedge clk); #2;
        bus_sel = 1'b0; cl_ld = 1'b1; cl_re = 16'hF00F; cl_im = 16'h0FF0;
        idle();
        chk({30'h0, acc_re}, {30'h0, f_bas(16'hF00F)}, "R7 basic real");
        chk({30'h0, acc_im}, {30'h0, f_bas(16'h0FF0)}, "R7 basic imag");

        // R8 extended command-list load
        @(posedge clk); #2;
        cl_xld = 1'b1; cl_xre = 31'h4000_0003; cl_xim = 31'h1555_5555;
        idle();
        chk({30'h0, acc_re}, {30'h0, f_ext(31'h4000_0003)}, "R8 ext real");
        chk({30'h0, acc_im}, {30'h0, f_ext(31'h1555_5555)}, "R8 ext imag");

        // R9 priority: basic over core, extended over basic
        @(posedge clk); #2;
        bus_sel = 1'b1; bus_we = 1'b1; bus_dword = 1'b1; bus_addr = 13'h014; bus_wdata = 32'h1111_2222;
        cl_ld = 1'b1; cl_re = 16'hAAAA; cl_im = 16'h5555;
        idle();
        chk({30'h0, acc_re}, {30'h0, f_bas(16'hAAAA)}, "R9 basic beats core real");
        chk({30'h0, acc_im}, {30'h0, f_bas(16'h5555)}, "R9 basic beats core imag");
        @(posedge clk); #2;
        cl_ld = 1'b1; cl_re = 16'h0001; cl_im = 16'h0001;
        cl_xld = 1'b1; cl_xre = 31'h0000_1234; cl_xim = 31'h7FFF_FFFF;
        idle();
        chk({30'h0, acc_re}, {30'h0, f_ext(31'h0000_1234)}, "R9 ext beats basic real");
        chk({30'h0, acc_im}, 64'h3_FFFF_FFFF, "R9 ext beats basic imag");

        // R10 misaligned accesses
        wr(1, 13'h016, 32'hFFFF_FFFF);
        idle();
        chk({63'h0, bus_err}, 64'h1, "R10 err after misaligned write");
        chk({30'h0, acc_re}, {30'h0, f_ext(31'h0000_1234)}, "R10 acc real unchanged");
        chk({30'h0, acc_im}, 64'h3_FFFF_FFFF, "R10 acc imag unchanged");
        idle();
        chk({63'h0, bus_err}, 64'h0, "R10 err lasts one cycle");
        wr(0, 13'h009, 32'h0000_0000);
        rd(1, 13'h008, 32'hBEEF_5678, "R10 misaligned word write ignored");
        rd(1, 13'h00A, 32'h0, "R10 misaligned read returns zero");

        // R11 unmapped offsets
        wr(1, 13'h01C, 32'hDEAD_BEEF);
        idle();
        chk({63'h0, bus_err}, 64'h0, "R11 no error on unmapped write");
        rd(1, 13'h01C, 32'h0, "R11 unmapped gap reads zero");
        rd(1, 13'h1018, 32'h0, "R11 past end reads zero");

        repeat (3) idle();
        chk({32'h0, 32'(exp_q.size())}, 64'h0, "scoreboard drained");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule